// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block sits beside the byte-level engine of an SMBus or PMBus target. It watches the byte stream that engine hands it, together with strobes that mark a start condition, a repeated start, an address byte and a stop. It keeps a running CRC-8 with polynomial 0x07 over every byte of the message. The running value covers the write address and command bytes that come before a repeated-start read.

On a read, the target appends the PEC. The byte engine takes `pecOut` as the byte it shifts out after the last data byte.

On a write, the host appends the PEC. At the stop condition the block gives one verdict:
- an accept pulse, which allows the command to execute;
- a mismatch pulse, which the alert logic treats as an error event;
- a missing-PEC pulse, for a write too short to carry a PEC. Such a write is refused.

A read sent to the global broadcast address gets its own pulse, so that it can be reported as an invalid command.

Top module: `smbus_pec_unit`

## Requirements
- R1: After reset `pecOut` is 0x00 and `pecOk`, `pecError`, `pecMissing` and `globalRead` are all 0.
- R2: A cycle with `isStart` high sets `pecOut` to 0x00. Each later cycle with `byteValid` high updates `pecOut` by one step of CRC-8 (polynomial 0x07, MSB first, no final inversion) over `byteData`, one cycle after the byte.
- R3: `isRestart` does not clear the CRC. The value after a repeated start continues over the bytes of both address phases.
- R4: If `isStop` comes while the last address byte had bit 0 = 0 (write), at least 2 bytes followed that address, and the CRC over all message bytes is 0x00, then `pecOk` pulses in the cycle after the stop.
- R5: For a write as in R4 with at least 2 bytes after the address but a nonzero CRC, `pecError` pulses in the cycle after the stop.
- R6: For a write with fewer than 2 bytes after the write address, `pecMissing` pulses in the cycle after the stop and `pecOk` stays 0.
- R7: A stop that ends a message whose last address byte had bit 0 = 1 (read) produces no verdict pulse.
- R8: An address byte equal to 0x01 (general-call address 0 with the read bit) pulses `globalRead` in the next cycle. Any other address byte does not.
- R9: Cycles without `byteValid` or `isStart` leave `pecOut` unchanged.
- R10: At most one of `pecOk`, `pecError`, `pecMissing` is high in any cycle, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isStart | input | 1 | Start condition strobe |
| isRestart | input | 1 | Repeated start strobe |
| isStop | input | 1 | Stop condition strobe |
| byteValid | input | 1 | A bus byte, in either direction, is on `byteData` |
| isAddr | input | 1 | The current byte is an address byte |
| byteData | input | 8 | Byte value, address bit 0 = R/W |
| pecOut | output | 8 | Running CRC, used as the PEC to append on reads |
| pecOk | output | 1 | Write PEC matched; the command may execute |
| pecError | output | 1 | Write PEC mismatch event |
| pecMissing | output | 1 | Write too short to carry a PEC; refused |
| globalRead | output | 1 | Read sent to the global broadcast address |

## Verification
Random writes of 0 to 4 bytes after the address are sent with a correct PEC, a corrupted last byte, or no PEC. These three cases separate accept, mismatch and missing-PEC, and the short lengths reach the 2-byte boundary. Write-then-repeated-start-read messages with random data, checked against a bench CRC, show whether the CRC is kept across the repeated start and whether a read stop is kept free of verdicts. Directed cases cover the 0x01 address byte against a 0x00 global write, idle cycles between bytes, and a known-answer CRC.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic clear;     // start condition: restart the CRC
    logic update;    // fold byteData into the CRC
    logic markAddr;  // byte is an address: latch direction, reset count
    logic evalStop;  // stop condition: give the write verdict
  } pecCtl_t;

  function automatic logic [BYTE_W-1:0] crcStep(
    input logic [BYTE_W-1:0] crc,
    input logic [BYTE_W-1:0] data,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] x;
    x = crc ^ data;
    for (int i = 0; i < BYTE_W; i++)
      x = x[BYTE_W-1] ? ((x << 1) ^ poly) : (x << 1);
    return x;
  endfunction
endpackage

// File: rtl/pec_datapath.sv
module pec_datapath
  import pec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07,
  parameter int MIN_WR_BYTES = 2,
  localparam int CNT_W = $clog2(MIN_WR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pecCtl_t           ctl,
  input  logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] crc,
  output logic [CNT_W-1:0]  wrCnt,
  output logic              wrPhase
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_WR_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) crc <= '0;
    else if (ctl.update)    crc <= crcStep(crc, byteData, POLY);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear || ctl.markAddr) wrCnt <= '0;
    else if (ctl.update && wrCnt != CNT_MAX) wrCnt <= wrCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) wrPhase <= 1'b0;
    else if (ctl.markAddr)  wrPhase <= ~byteData[0];
  end
endmodule

// File: rtl/pec_control.sv
module pec_control
  import pec_pkg::*;
#(
  parameter int MIN_WR_BYTES = 2,
  parameter logic [6:0] GLOBAL_ADDR = 7'h00,
  localparam int CNT_W = $clog2(MIN_WR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isStart,
  input  logic              isStop,
  input  logic              byteValid,
  input  logic              isAddr,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [BYTE_W-1:0] crc,
  input  logic [CNT_W-1:0]  wrCnt,
  input  logic              wrPhase,
  output pecCtl_t           ctl,
  output logic              pecOk,
  output logic              pecError,
  output logic              pecMissing,
  output logic              globalRead
);
  localparam logic [BYTE_W-1:0] GLOBAL_RD = {GLOBAL_ADDR, 1'b1};

  always_comb begin
    ctl.clear    = isStart;
    ctl.update   = byteValid && !isStart;
    ctl.markAddr = byteValid && isAddr && !isStart;
    ctl.evalStop = isStop;
  end

  logic shortWr;
  assign shortWr = wrCnt < CNT_W'(MIN_WR_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pecOk      <= 1'b0;
      pecError   <= 1'b0;
      pecMissing <= 1'b0;
      globalRead <= 1'b0;
    end else begin
      pecOk      <= ctl.evalStop && wrPhase && !shortWr && crc == '0;
      pecError   <= ctl.evalStop && wrPhase && !shortWr && crc != '0;
      pecMissing <= ctl.evalStop && wrPhase && shortWr;
      globalRead <= ctl.markAddr && byteData == GLOBAL_RD;
    end
  end
endmodule

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit
  import pec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07,
  parameter int MIN_WR_BYTES = 2,
  parameter logic [6:0] GLOBAL_ADDR = 7'h00,
  localparam int CNT_W = $clog2(MIN_WR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isStart,
  input  logic              isRestart,
  input  logic              isStop,
  input  logic              byteValid,
  input  logic              isAddr,
  input  logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] pecOut,
  output logic              pecOk,
  output logic              pecError,
  output logic              pecMissing,
  output logic              globalRead
);
  pecCtl_t          ctl;
  logic [CNT_W-1:0] wrCnt;
  logic             wrPhase;
  logic             restartSeen;

  // A repeated start keeps the running CRC; it is a marker only.
  assign restartSeen = isRestart;

  pec_control #(.MIN_WR_BYTES(MIN_WR_BYTES), .GLOBAL_ADDR(GLOBAL_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .isStart(isStart), .isStop(isStop && !restartSeen),
    .byteValid(byteValid), .isAddr(isAddr), .byteData(byteData),
    .crc(pecOut), .wrCnt(wrCnt), .wrPhase(wrPhase), .ctl(ctl),
    .pecOk(pecOk), .pecError(pecError), .pecMissing(pecMissing),
    .globalRead(globalRead)
  );

  pec_datapath #(.POLY(POLY), .MIN_WR_BYTES(MIN_WR_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteData(byteData),
    .crc(pecOut), .wrCnt(wrCnt), .wrPhase(wrPhase)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker (
  input logic       clk,
  input logic       rstN,
  input logic       isStart,
  input logic       isRestart,
  input logic       isStop,
  input logic       byteValid,
  input logic       isAddr,
  input logic [7:0] byteData,
  input logic [7:0] pecOut,
  input logic       pecOk,
  input logic       pecError,
  input logic       pecMissing,
  input logic       globalRead
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> pecOut == 8'h00);

  p_restart_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isRestart && !byteValid && !isStart) |=> $stable(pecOut));

  p_ok_after_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    pecOk |-> $past(isStop));

  p_err_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    pecError |-> $past(isStop));

  p_global_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && isAddr && !isStart && byteData == 8'h01) |=> globalRead);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !isStart) |=> $stable(pecOut));

  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pecOk, pecError, pecMissing}));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pecOk || pecError || pecMissing) |=> !(pecOk || pecError || pecMissing));
endmodule

bind smbus_pec_unit pec_checker chk (
  .clk(clk), .rstN(rstN), .isStart(isStart), .isRestart(isRestart),
  .isStop(isStop), .byteValid(byteValid), .isAddr(isAddr),
  .byteData(byteData), .pecOut(pecOut), .pecOk(pecOk),
  .pecError(pecError), .pecMissing(pecMissing), .globalRead(globalRead)
);

// File: tb/smbus_pec_unit_test.sv
module smbus_pec_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isStart = 0, isRestart = 0, isStop = 0, byteValid = 0, isAddr = 0;
  logic [7:0] byteData = '0;
  logic [7:0] pecOut;
  logic pecOk, pecError, pecMissing, globalRead;

  int nChecks = 0, nFail = 0;
  logic [7:0] mCrc;
  int mCnt;

  always #5 clk = ~clk;

  smbus_pec_unit uut (
    .clk(clk), .rstN(rstN), .isStart(isStart), .isRestart(isRestart),
    .isStop(isStop), .byteValid(byteValid), .isAddr(isAddr),
    .byteData(byteData), .pecOut(pecOut), .pecOk(pecOk),
    .pecError(pecError), .pecMissing(pecMissing), .globalRead(globalRead)
  );

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    isStart = 0; isRestart = 0; isStop = 0; byteValid = 0; isAddr = 0;
  endtask

  task automatic doStart();
    isStart = 1; tick(); mCrc = 8'h00; mCnt = 0;
  endtask

  task automatic doRestart();
    isRestart = 1; tick();
  endtask

  task automatic sendByte(input logic [7:0] d, input bit addr);
    byteValid = 1; isAddr = addr; byteData = d; tick();
    mCrc = refCrc(mCrc, d);
    mCnt = addr ? 0 : mCnt + 1;
  endtask

  task automatic doStop();
    isStop = 1; tick();
  endtask

  task automatic expectVerdict(input string req, input bit ok, input bit er, input bit ms);
    check(req, {pecOk, pecError, pecMissing}, {ok, er, ms});
    tick();
    check("R10", {pecOk, pecError, pecMissing}, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    check("R1", {pecOut, pecOk, pecError, pecMissing, globalRead}, 12'h000);
    rstN = 1; tick();

    // Known answer: CRC-8/0x07 of ASCII "123456789" is 0xF4 (R2)
    doStart();
    for (int i = 0; i < 9; i++) sendByte(8'h31 + 8'(i), i == 0);
    check("R2", pecOut, 8'hF4);
    repeat (3) tick();
    check("R9", pecOut, 8'hF4);
    isRestart = 1; tick();
    check("R3", pecOut, 8'hF4);
    doStart();
    check("R2", pecOut, 8'h00);

    // Global broadcast read vs global write (R8)
    sendByte(8'h01, 1);
    check("R8", globalRead, 1'b1);
    doStop();
    check("R7", {pecOk, pecError, pecMissing}, 3'b000);
    doStart(); sendByte(8'h00, 1);
    check("R8", globalRead, 1'b0);
    sendByte(8'h55, 0);
    doStop();
    expectVerdict("R6", 0, 0, 1);

    // Quick write, no byte after address (R6)
    doStart(); sendByte(8'hB0, 1); doStop();
    expectVerdict("R6", 0, 0, 1);

    // Random writes
    for (int t = 0; t < 60; t++) begin
      int n = int'($urandom_range(0, 4));
      int mode = int'($urandom_range(0, 2));
      logic [7:0] a = {7'($urandom_range(1, 127)), 1'b0};
      bit xOk, xEr, xMs;
      doStart(); sendByte(a, 1);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d = 8'($urandom);
        if (k == n - 1 && mode != 2) d = (mode == 0) ? mCrc : (mCrc ^ 8'h5A);
        if ($urandom_range(0, 3) == 0) tick();
        sendByte(d, 0);
      end
      check("R2", pecOut, mCrc);
      xMs = mCnt < 2;
      xOk = !xMs && mCrc == 8'h00;
      xEr = !xMs && mCrc != 8'h00;
      doStop();
      expectVerdict(xOk ? "R4" : (xEr ? "R5" : "R6"), xOk, xEr, xMs);
    end

    // Random write-then-read messages across a repeated start
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a7 = 7'($urandom_range(1, 127));
      int n = int'($urandom_range(1, 4));
      doStart(); sendByte({a7, 1'b0}, 1); sendByte(8'($urandom), 0);
      doRestart();
      check("R3", pecOut, mCrc);
      sendByte({a7, 1'b1}, 1);
      check("R8", globalRead, 1'b0);
      for (int k = 0; k < n; k++) sendByte(8'($urandom), 0);
      check("R3", pecOut, mCrc);
      sendByte(mCrc, 0);
      doStop();
      expectVerdict("R7", 0, 0, 0);
    end

    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule